// File: doc/BRIEF.md
# Receive Descriptor-Ring DMA Channel

This block is the receive side of a descriptor-driven DMA engine. Software builds a ring of 16-byte descriptors in memory, each naming a buffer and its byte count, and moves a last-posted pointer forward as it hands descriptors to the channel. The channel fetches descriptors on its own and takes frames from a byte stream that marks each frame's last byte. It stores the bytes into the posted buffers.

Data in a frame's first buffer starts a programmable number of bytes past the buffer start. When that buffer fills, the frame continues at byte 0 of the next descriptor's buffer. Once the last byte is stored, the channel writes a 32-bit status word at the start of the first buffer. This word gives the stored length, an overflow flag and the number of extra descriptors used. The channel then moves its current pointer past every descriptor the frame consumed.

The channel reports a state code, an error code and two ring offsets on two status words. It has two policies for running out of descriptors in the middle of a frame: stop with an error, or drop the rest of the frame. The memory port is a plain synchronous port. A read returns data one cycle after the request, and writes carry byte enables.

Top module: `rxdma_rx_channel`

## Requirements
- R1: After reset, `stat0` and `stat1` read 0, `in_ready` is 0 and no memory write is issued.
- R2: `stat0[31:28]` holds the state: 0 disabled, 1 active, 2 idle wait, 3 stopped. An enabled channel whose current offset equals `last_ptr`, with no frame in progress, reports 2 and holds `in_ready` low. `stat0[12:0]` is the current descriptor offset and `stat1[12:0]` the fetch offset.
- R3: Each descriptor is read as four 32-bit words at `ring_base` + offset + 0/4/8/12. Word 0 bit 28 marks the end of the table. Word 1 bits 14:0 hold the buffer byte count. Word 2 holds the word-aligned buffer address. Word 3 takes part only in the parity check.
- R4: Bytes of a frame go into the first buffer from address buffer + `cfg_offset`. Each accepted beat writes one byte, with the address's low two bits selecting the single byte enable and the byte placed on that lane.
- R5: When the first buffer is full, the following bytes go into the next descriptor's buffer from its byte 0, with no status word in that buffer.
- R6: After a frame's last byte is stored, the channel writes one full word (all four enables) at the first buffer's address. The word holds the stored length in bits 15:0, the overflow flag in bit 23, descriptors used minus one in bits 27:24, and zero in bits 31:28.
- R7: The current offset changes only after the status word is written. It then moves past every descriptor the frame used, going back to 0 after a descriptor with the end-of-table bit and otherwise adding 16.
- R8: If a frame needs another descriptor and none is posted while `cfg_ovf_continue` is 1, the rest of the frame is accepted and discarded, and its status word has the overflow flag set.
- R9: In the same case with `cfg_ovf_continue` 0, the channel stops (state 3) with error code 2 in `stat1[31:28]`, drops `in_ready`, writes no status word and leaves the current offset unchanged.
- R10: A descriptor with a byte count of 0, or a first-buffer descriptor whose byte count does not exceed `cfg_offset`, stops the channel with error code 1.
- R11: With `cfg_parity_off` 0, a descriptor whose four words XOR to a value of odd parity stops the channel with error code 4. With `cfg_parity_off` 1, the parity of a descriptor has no effect.
- R12: Clearing `cfg_enable` gives state 0 at once when no frame is in progress, and only after the status write when a frame is in progress. Setting it again clears the error code and resumes fetching at the current offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_offset | input | RO_W | Byte offset of data in the first buffer |
| cfg_ovf_continue | input | 1 | Drop the rest of a frame instead of stopping when descriptors run out |
| cfg_parity_off | input | 1 | Skip the descriptor parity check |
| ring_base | input | ADDR_W | Byte address of the descriptor ring |
| last_ptr | input | OFF_W | Ring offset one past the last posted descriptor |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte ends the frame |
| in_ready | output | 1 | Channel accepts a byte this cycle |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read byte address |
| mem_rd_data | input | 32 | Read data, one cycle after the request |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_addr | output | ADDR_W | Memory write byte address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_be | output | 4 | Write byte enables |
| stat0 | output | 32 | State code and current descriptor offset |
| stat1 | output | 32 | Error code and fetch offset |

## Verification
The bench builds the channel with its default parameters: 32-bit addresses, a 13-bit ring offset, 15-bit byte counts, a 7-bit data offset, 16-bit lengths and a 4-bit descriptor counter. These values fit a four-entry ring, small buffers and offsets of 4 and 8 into a 2 KB memory model. A single scatter frame then crosses three buffers and the end-of-table wrap. The other directed frames run out of descriptors under both overflow policies. Descriptors with corrupted parity and undersized buffers are fetched with the parity check enabled and disabled.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

   typedef enum logic [3:0] {
      RXS_DISABLED = 4'd0,
      RXS_ACTIVE   = 4'd1,
      RXS_IDLE     = 4'd2,
      RXS_STOPPED  = 4'd3,
      RXS_SUSPEND  = 4'd4
   } rx_state_code_e;

   typedef enum logic [3:0] {
      RXE_NONE       = 4'd0,
      RXE_DESC_PROTO = 4'd1,
      RXE_FIFO_OVF   = 4'd2,
      RXE_XFER       = 4'd3,
      RXE_DESC_READ  = 4'd4,
      RXE_CORE       = 4'd5
   } rx_err_e;

   typedef enum logic [2:0] {
      F_OFF, F_WAIT, F_FETCH, F_DATA, F_NEXT, F_DROP, F_STATUS, F_STOP
   } rx_fsm_e;

endpackage

// File: rtl/rxdma_ring_ptr.sv
module rxdma_ring_ptr #(
   parameter int OFF_W      = 13,
   parameter int DESC_BYTES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload,
   input  logic             step,
   input  logic             eot,
   input  logic             commit,
   output logic [OFF_W-1:0] cur_off,
   output logic [OFF_W-1:0] fetch_off
);
   localparam logic [OFF_W-1:0] STRIDE = OFF_W'(DESC_BYTES);

   if (DESC_BYTES < 4 || (DESC_BYTES & (DESC_BYTES - 1)) != 0) begin : g_bad_stride
      $error("descriptor stride must be a power of two of at least 4");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_off   <= '0;
         fetch_off <= '0;
      end else begin
         if (reload)
            fetch_off <= cur_off;
         else if (step)
            fetch_off <= eot ? '0 : fetch_off + STRIDE;
         if (commit)
            cur_off <= fetch_off;
      end
   end
endmodule

// File: rtl/rxdma_hdr_pack.sv
module rxdma_hdr_pack #(
   parameter int LEN_W  = 16,
   parameter int DCNT_W = 4
) (
   input  logic [LEN_W-1:0]  len,
   input  logic [DCNT_W-1:0] dcnt,
   input  logic              ovf,
   output logic [31:0]       word
);
   if (LEN_W > 16 || LEN_W < 1) begin : g_bad_len
      $error("length field is limited to 16 bits");
   end
   if (DCNT_W > 4 || DCNT_W < 1) begin : g_bad_dcnt
      $error("descriptor count field is limited to 4 bits");
   end

   always_comb begin
      word               = '0;
      word[LEN_W-1:0]    = len;
      word[23]           = ovf;
      word[24 +: DCNT_W] = dcnt;
   end
endmodule

// File: rtl/rxdma_lane_steer.sv
module rxdma_lane_steer #(
   parameter int LANES = 4
) (
   input  logic [$clog2(LANES)-1:0] lane_sel,
   input  logic [7:0]               byte_in,
   input  logic                     full,
   input  logic [8*LANES-1:0]       word_in,
   output logic [8*LANES-1:0]       data_out,
   output logic [LANES-1:0]         be_out
);
   localparam int SEL_W = $clog2(LANES);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("lane count must be a power of two");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign data_out[8*l +: 8] = full ? word_in[8*l +: 8] : byte_in;
      assign be_out[l]          = full || (lane_sel == SEL_W'(l));
   end
endmodule

// File: rtl/rxdma_rx_channel.sv
module rxdma_rx_channel
   import rxdma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 13,
   parameter int BC_W   = 15,
   parameter int RO_W   = 7,
   parameter int LEN_W  = 16,
   parameter int DCNT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic [RO_W-1:0]   cfg_offset,
   input  logic              cfg_ovf_continue,
   input  logic              cfg_parity_off,
   input  logic [ADDR_W-1:0] ring_base,
   input  logic [OFF_W-1:0]  last_ptr,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic              in_last,
   output logic              in_ready,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [31:0]       mem_rd_data,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [31:0]       mem_wr_data,
   output logic [3:0]        mem_wr_be,
   output logic [31:0]       stat0,
   output logic [31:0]       stat1
);
   localparam int LANES      = 4;
   localparam int DESC_BYTES = 16;
   localparam int DESC_WORDS = DESC_BYTES / LANES;
   localparam int STAT_PAD   = 28 - OFF_W;
   localparam int OFS_EXT    = BC_W - RO_W;
   localparam int PTR_EXT    = ADDR_W - OFF_W;
   localparam logic [2:0] LAST_BEAT = 3'(DESC_WORDS);

   if (ADDR_W > 32 || ADDR_W <= OFF_W) begin : g_bad_addr
      $error("address width must exceed the ring offset width and fit 32 bits");
   end
   if (OFF_W > 28 || OFF_W < 5) begin : g_bad_off
      $error("ring offset width out of range");
   end
   if (BC_W > 15 || BC_W <= RO_W) begin : g_bad_bc
      $error("byte count width must exceed offset width and fit bits 14:0");
   end

   rx_fsm_e               fsm_q;
   rx_err_e               err_q;
   logic [2:0]            fcnt_q;
   logic                  eot_q, par_q, first_q, ovf_q;
   logic [BC_W-1:0]       bc_q, room_q;
   logic [ADDR_W-1:0]     buf_q, wr_ptr_q, hdr_addr_q;
   logic [LEN_W-1:0]      len_q;
   logic [DCNT_W-1:0]     dcnt_q;
   logic [OFF_W-1:0]      cur_off, fetch_off;
   logic [31:0]           hdr_word;
   logic [3:0]            state_code;

   wire              beat      = in_valid && in_ready;
   wire [BC_W-1:0]   ofs_ext   = {{OFS_EXT{1'b0}}, cfg_offset};
   wire              desc_more = fetch_off != last_ptr;
   wire              fetch_end = (fsm_q == F_FETCH) && (fcnt_q == LAST_BEAT);
   wire              par_bad   = !cfg_parity_off && (par_q ^ (^mem_rd_data));
   wire              bc_bad    = (bc_q == '0) || (first_q && bc_q <= ofs_ext);
   wire              ptr_reload = (fsm_q == F_OFF) && cfg_enable;
   wire              ptr_step   = fetch_end && !par_bad && !bc_bad;
   wire              ptr_commit = fsm_q == F_STATUS;

   rxdma_ring_ptr #(.OFF_W(OFF_W), .DESC_BYTES(DESC_BYTES)) u_ptr (
      .clk(clk), .rst_n(rst_n), .reload(ptr_reload), .step(ptr_step),
      .eot(eot_q), .commit(ptr_commit), .cur_off(cur_off), .fetch_off(fetch_off));

   rxdma_hdr_pack #(.LEN_W(LEN_W), .DCNT_W(DCNT_W)) u_hdr (
      .len(len_q), .dcnt(dcnt_q), .ovf(ovf_q), .word(hdr_word));

   rxdma_lane_steer #(.LANES(LANES)) u_lane (
      .lane_sel(wr_ptr_q[1:0]), .byte_in(in_data), .full(fsm_q == F_STATUS),
      .word_in(hdr_word), .data_out(mem_wr_data), .be_out(mem_wr_be));

   assign in_ready    = (fsm_q == F_DATA) || (fsm_q == F_DROP);
   assign mem_rd_en   = (fsm_q == F_FETCH) && (fcnt_q != LAST_BEAT);
   assign mem_rd_addr = ring_base + {{PTR_EXT{1'b0}}, fetch_off}
                        + ADDR_W'({fcnt_q[1:0], 2'b00});
   assign mem_wr_en   = ((fsm_q == F_DATA) && beat) || (fsm_q == F_STATUS);
   assign mem_wr_addr = (fsm_q == F_STATUS) ? hdr_addr_q : wr_ptr_q;

   always_comb begin
      case (fsm_q)
         F_OFF:   state_code = RXS_DISABLED;
         F_STOP:  state_code = RXS_STOPPED;
         F_WAIT:  state_code = (cur_off == last_ptr) ? RXS_IDLE : RXS_ACTIVE;
         default: state_code = RXS_ACTIVE;
      endcase
   end

   assign stat0 = {state_code, {STAT_PAD{1'b0}}, cur_off};
   assign stat1 = {err_q, {STAT_PAD{1'b0}}, fetch_off};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsm_q <= F_OFF;       err_q <= RXE_NONE;    fcnt_q <= '0;
         eot_q <= 1'b0;        par_q <= 1'b0;        first_q <= 1'b1;
         ovf_q <= 1'b0;        bc_q <= '0;           room_q <= '0;
         buf_q <= '0;          wr_ptr_q <= '0;       hdr_addr_q <= '0;
         len_q <= '0;          dcnt_q <= '0;
      end else begin
         case (fsm_q)
            F_OFF: if (cfg_enable) begin
               fsm_q <= F_WAIT;  err_q <= RXE_NONE;  first_q <= 1'b1;
               len_q <= '0;      dcnt_q <= '0;       ovf_q <= 1'b0;
            end
            F_WAIT: begin
               if (!cfg_enable) fsm_q <= F_OFF;
               else if (desc_more) begin
                  fsm_q <= F_FETCH;  fcnt_q <= '0;  par_q <= 1'b0;
               end
            end
            F_FETCH: begin
               fcnt_q <= fcnt_q + 3'd1;
               if (fcnt_q != '0) par_q <= par_q ^ (^mem_rd_data);
               case (fcnt_q)
                  3'd1: eot_q <= mem_rd_data[28];
                  3'd2: bc_q  <= mem_rd_data[BC_W-1:0];
                  3'd3: buf_q <= mem_rd_data[ADDR_W-1:0];
                  default: ;
               endcase
               if (fetch_end) begin
                  if (par_bad) begin
                     err_q <= RXE_DESC_READ;  fsm_q <= F_STOP;
                  end else if (bc_bad) begin
                     err_q <= RXE_DESC_PROTO; fsm_q <= F_STOP;
                  end else begin
                     fsm_q <= F_DATA;
                     if (first_q) begin
                        hdr_addr_q <= buf_q;
                        wr_ptr_q   <= buf_q + ADDR_W'(cfg_offset);
                        room_q     <= bc_q - ofs_ext;
                     end else begin
                        wr_ptr_q <= buf_q;
                        room_q   <= bc_q;
                        dcnt_q   <= dcnt_q + 1'b1;
                     end
                  end
               end
            end
            F_DATA: begin
               if (!cfg_enable && first_q && len_q == '0 && !in_valid)
                  fsm_q <= F_OFF;
               else if (beat) begin
                  wr_ptr_q <= wr_ptr_q + 1'b1;
                  room_q   <= room_q - 1'b1;
                  len_q    <= len_q + 1'b1;
                  if (in_last)                 fsm_q <= F_STATUS;
                  else if (room_q == BC_W'(1)) fsm_q <= F_NEXT;
               end
            end
            F_NEXT: begin
               first_q <= 1'b0;
               if (desc_more) begin
                  fsm_q <= F_FETCH;  fcnt_q <= '0;  par_q <= 1'b0;
               end else if (cfg_ovf_continue) begin
                  ovf_q <= 1'b1;  fsm_q <= F_DROP;
               end else begin
                  err_q <= RXE_FIFO_OVF;  fsm_q <= F_STOP;
               end
            end
            F_DROP: if (beat && in_last) fsm_q <= F_STATUS;
            F_STATUS: begin
               fsm_q <= F_WAIT;  first_q <= 1'b1;  len_q <= '0;
               dcnt_q <= '0;     ovf_q <= 1'b0;
            end
            F_STOP: if (!cfg_enable) fsm_q <= F_OFF;
            default: fsm_q <= F_OFF;
         endcase
      end
   end

   // R6
   hdr_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_en && mem_wr_be == 4'hF) |-> $past(in_valid && in_ready && in_last));

   // R4
   lane_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ($countones(mem_wr_be) == 1 || mem_wr_be == 4'hF));

   // R9
   err_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat1[31:28] != 4'd0) |-> (stat0[31:28] == 4'd3 || stat0[31:28] == 4'd0));

   // R7
   cur_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stat0[OFF_W-1:0]) |-> $past(mem_wr_en && mem_wr_be == 4'hF));

   // R3
   rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (((mem_rd_addr - ring_base) >> OFF_W) == '0));

endmodule

// File: tb/rxdma_rx_channel_tb.sv
module rxdma_rx_channel_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] RING = 32'h100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_enable = 1'b0, cfg_ovf_continue = 1'b0, cfg_parity_off = 1'b0;
   logic [6:0]  cfg_offset = 7'd4;
   logic [31:0] ring_base = RING;
   logic [12:0] last_ptr = '0;
   logic in_valid = 1'b0, in_last = 1'b0;
   logic [7:0] in_data = '0;
   logic in_ready, mem_rd_en, mem_wr_en;
   logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data, stat0, stat1;
   logic [31:0] mem_rd_data = '0;
   logic [3:0]  mem_wr_be;
   logic [31:0] mem [0:511];
   int n_chk = 0, n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxdma_rx_channel dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_offset(cfg_offset),
      .cfg_ovf_continue(cfg_ovf_continue), .cfg_parity_off(cfg_parity_off),
      .ring_base(ring_base), .last_ptr(last_ptr), .in_valid(in_valid),
      .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_wr_be(mem_wr_be), .stat0(stat0), .stat1(stat1));

   always @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[10:2]];
      if (mem_wr_en)
         for (int l = 0; l < 4; l++)
            if (mem_wr_be[l]) mem[mem_wr_addr[10:2]][8*l +: 8] <= mem_wr_data[8*l +: 8];
   end

   function automatic logic [7:0] get_byte(input int a);
      return mem[a[10:2]][8*a[1:0] +: 8];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put_desc(input int off, input bit eot, input int bc, input int addr,
                           input bit bad_par);
      logic [31:0] w0, w1, w2, w3;
      w0 = eot ? 32'h1000_0000 : 32'h0;
      w1 = 32'(bc) & 32'h7FFF;
      w2 = 32'(addr);
      w3 = 32'h0;
      if ((^(w0 ^ w1 ^ w2 ^ w3)) ^ bad_par) w1[18] = 1'b1;
      mem[(RING + 32'(off)) >> 2]       = w0;
      mem[((RING + 32'(off)) >> 2) + 1] = w1;
      mem[((RING + 32'(off)) >> 2) + 2] = w2;
      mem[((RING + 32'(off)) >> 2) + 3] = w3;
   endtask

   task automatic send_bytes(input int n, input int seed, input bit with_last,
                             input int max_wait, output int acc);
      acc = 0;
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
         int w;
         in_valid = 1'b1;
         in_data  = 8'(seed + i);
         in_last  = with_last && (i == n - 1);
         w = 0;
         while (!in_ready && w < max_wait) begin @(negedge clk); w++; end
         if (!in_ready) break;
         @(negedge clk);
         acc++;
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic wait_code(input logic [3:0] code);
      for (int w = 0; w < 100; w++) begin
         if (stat0[31:28] == code) break;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      chk("R1 stat0", stat0, 32'h0);
      chk("R1 stat1", stat1, 32'h0);
      chk("R1 in_ready", 32'(in_ready), 32'h0);
      chk("R1 no write", 32'(mem_wr_en), 32'h0);
   endtask

   task automatic t_idle();
      cfg_enable = 1'b1;
      repeat (3) @(negedge clk);
      chk("R2 idle wait", stat0, 32'h2000_0000);
      chk("R2 in_ready low when idle", 32'(in_ready), 32'h0);
   endtask

   task automatic t_single();
      int acc;
      put_desc(32'h00, 1'b0, 64, 32'h400, 1'b0);
      last_ptr = 13'h010;
      repeat (3) @(negedge clk);
      chk("R2 active with posted descriptor", 32'(stat0[31:28]), 32'h1);
      send_bytes(10, 32'h20, 1'b1, 50, acc);
      wait_code(4'd2);
      chk("R6 single-buffer status word", mem[32'h400 >> 2], 32'h0000_000A);
      chk("R4 first byte at offset", 32'(get_byte(32'h404)), 32'h20);
      chk("R3 R4 last byte", 32'(get_byte(32'h40D)), 32'h29);
      chk("R4 nothing past frame", 32'(get_byte(32'h40E)), 32'h0);
      chk("R7 cur advanced one descriptor", stat0, 32'h2000_0010);
   endtask

   task automatic t_scatter();
      int acc;
      cfg_offset = 7'd8;
      put_desc(32'h10, 1'b0, 16, 32'h440, 1'b0);
      put_desc(32'h20, 1'b0, 16, 32'h460, 1'b0);
      put_desc(32'h30, 1'b1, 16, 32'h480, 1'b0);
      last_ptr = 13'h000;
      send_bytes(30, 32'h40, 1'b1, 50, acc);
      wait_code(4'd2);
      chk("R6 scatter status dcnt=2", mem[32'h440 >> 2], 32'h0200_001E);
      chk("R4 offset 8 placement", 32'(get_byte(32'h448)), 32'h40);
      chk("R5 continuation at buffer start", 32'(get_byte(32'h460)), 32'h48);
      chk("R5 third buffer end", 32'(get_byte(32'h485)), 32'h5D);
      chk("R5 no spill", 32'(get_byte(32'h486)), 32'h0);
      chk("R7 wrap after end-of-table", stat0, 32'h2000_0000);
   endtask

   task automatic t_ovf_cont();
      int acc;
      cfg_offset = 7'd4;
      cfg_ovf_continue = 1'b1;
      put_desc(32'h00, 1'b0, 16, 32'h500, 1'b0);
      last_ptr = 13'h010;
      send_bytes(20, 32'h70, 1'b1, 50, acc);
      wait_code(4'd2);
      chk("R8 whole frame accepted", 32'(acc), 32'd20);
      chk("R8 status with overflow flag", mem[32'h500 >> 2], 32'h0080_000C);
      chk("R8 last stored byte", 32'(get_byte(32'h50F)), 32'h7B);
      chk("R8 dropped bytes not stored", 32'(get_byte(32'h510)), 32'h0);
      chk("R8 ring state", stat0, 32'h2000_0010);
   endtask

   task automatic t_ovf_stop();
      int acc;
      cfg_ovf_continue = 1'b0;
      put_desc(32'h10, 1'b0, 16, 32'h520, 1'b0);
      last_ptr = 13'h020;
      send_bytes(20, 32'h90, 1'b1, 30, acc);
      repeat (2) @(negedge clk);
      chk("R9 bytes taken before stop", 32'(acc), 32'd12);
      chk("R9 stopped, cur unchanged", stat0, 32'h3000_0010);
      chk("R9 fifo overflow error", stat1, 32'h2000_0020);
      chk("R9 in_ready low", 32'(in_ready), 32'h0);
      chk("R9 no status word", mem[32'h520 >> 2], 32'h0);
      chk("R9 data stored", 32'(get_byte(32'h52F)), 32'h9B);
   endtask

   task automatic t_desc_errors();
      cfg_enable = 1'b0;
      repeat (2) @(negedge clk);
      chk("R12 disabled from stop", stat0, 32'h0000_0010);
      put_desc(32'h10, 1'b0, 16, 32'h540, 1'b1);
      cfg_enable = 1'b1;
      repeat (2) @(negedge clk);
      wait_code(4'd3);
      chk("R11 parity error code", stat1, 32'h4000_0010);
      chk("R11 parity error stops", stat0, 32'h3000_0010);
      cfg_enable = 1'b0;
      repeat (2) @(negedge clk);
      put_desc(32'h10, 1'b0, 4, 32'h540, 1'b0);
      cfg_enable = 1'b1;
      repeat (2) @(negedge clk);
      wait_code(4'd3);
      chk("R10 undersized first buffer", stat1, 32'h1000_0010);
      cfg_enable = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_enable_ctl();
      int acc;
      put_desc(32'h10, 1'b0, 32, 32'h540, 1'b1);
      cfg_parity_off = 1'b1;
      cfg_enable = 1'b1;
      repeat (8) @(negedge clk);
      chk("R11 R12 parity ignored, error cleared", 32'(stat1[31:28]), 32'h0);
      chk("R12 resumes at current offset", stat0, 32'h1000_0010);
      send_bytes(3, 32'hA0, 1'b0, 50, acc);
      cfg_enable = 1'b0;
      repeat (3) @(negedge clk);
      chk("R12 mid-frame disable waits", 32'(stat0[31:28]), 32'h1);
      send_bytes(3, 32'hA3, 1'b1, 50, acc);
      wait_code(4'd0);
      chk("R12 disabled after frame", stat0, 32'h0000_0020);
      chk("R6 frame completed", mem[32'h540 >> 2], 32'h0000_0006);
      chk("R4 bytes across disable", 32'(get_byte(32'h549)), 32'hA5);
      cfg_enable = 1'b1;
      repeat (3) @(negedge clk);
      chk("R2 idle again", stat0, 32'h2000_0020);
      cfg_enable = 1'b0;
      repeat (2) @(negedge clk);
      chk("R12 immediate disable when idle", stat0, 32'h0000_0020);
   endtask

   initial begin
      for (int i = 0; i < 512; i++) mem[i] = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle();
      t_single();
      t_scatter();
      t_ovf_cont();
      t_ovf_stop();
      t_desc_errors();
      t_enable_ctl();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule